// File: doc/BRIEF.md
# DAC Configuration Register and Power-On Recall

This block holds the 8-bit configuration byte of a dual-channel DAC and seeds the DAC data registers once after reset release. The bit cells themselves sit outside the block. The block reads the stored byte and the stored per-channel DAC codes. When a new configuration must be made permanent, it issues a one-cycle write pulse.

The configuration byte carries several fields:
- The upper nibble is the device type that the two-wire slave answers to for DAC traffic.
- Bit 3 sets the output impedance that the analog power-down switch uses.
- Bits 2:1 pick the power-on seed value.
- Bit 0 is a write-once lock.

The configuration byte has its own fixed device type, 1001. The slave writes it through a valid/ready byte port. A written byte is only staged. It takes effect, and is sent to storage, on the next bus stop. When locked, the register cannot be acknowledged, read or written again. The lock is part of the stored byte, so it survives every later reset. A blank store holds 8'h56.

Top module: `dac_cfg_recall`

## Requirements
- R1: After reset release the block captures the stored byte, then pulses `dac_load` high for exactly one cycle on all channels together (the second rising edge after release). `boot_done` rises with that pulse and stays high until reset. No further load pulse occurs.
- R2: Recall field `cfg[2:1]` = 00 seeds every channel with 10'h000.
- R3: Recall field 01 seeds 10'h3FF, and field 10 seeds mid-scale 10'h200.
- R4: Recall field 11 seeds each channel with its own stored code. Channel k takes `nv_dac_rd[k*10 +: 10]`, and `dac_value` is packed the same way.
- R5: `dev_type` equals `cfg[7:4]`. `dac_addr_ack` is high when `boot_done` is set, `bus_type` equals `dev_type`, and the configuration address is not acknowledged.
- R6: `cfg_addr_ack` is high exactly when `boot_done` is set, the register is unlocked, and `bus_type` is 4'b1001.
- R7: `pd_hiz` equals `cfg[3]`. A value of 1 means high impedance in power-down and 0 means low impedance to ground.
- R8: A byte accepted on the write port (`wr_valid && wr_ready`) changes nothing until `bus_stop`. On that stop the register takes the byte. In the following cycle `nv_cfg_wr_en` pulses once with the byte on `nv_cfg_wr_data`. A stop with no staged byte writes nothing.
- R9: Once the committed byte has bit 0 = 1, `wr_ready`, `rd_valid` and `cfg_addr_ack` are low and `rd_data` reads 0. Attempted writes and stops commit nothing. This persists across reset through the stored byte.
- R10: While `boot_done` is low, no address is acknowledged and `wr_ready` and `rd_valid` are low.
- R11: `rd_data` shows the committed register, never a byte that is only staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release starts the recall |
| nv_cfg_rd | input | 8 | Stored configuration byte |
| nv_dac_rd | input | 20 | Stored DAC codes, channel 0 in the low bits |
| nv_cfg_wr_en | output | 1 | One-cycle pulse committing a byte to storage |
| nv_cfg_wr_data | output | 8 | Byte to store |
| bus_type | input | 4 | Bits 7:4 of the received address byte |
| cfg_addr_ack | output | 1 | Acknowledge the configuration address |
| dac_addr_ack | output | 1 | Acknowledge the DAC address |
| wr_valid | input | 1 | Write byte valid |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte accepted this cycle if valid |
| bus_stop | input | 1 | One-cycle pulse on a bus stop condition |
| rd_valid | output | 1 | Read data available (level, no back-pressure) |
| rd_data | output | 8 | Committed configuration byte |
| dev_type | output | 4 | Programmed DAC device type |
| pd_hiz | output | 1 | Power-down output impedance select |
| boot_done | output | 1 | Recall complete; slave may answer traffic |
| dac_load | output | 2 | Per-channel load strobes |
| dac_value | output | 20 | Per-channel seed values |

Back-pressure rule: the slave holds `wr_valid` and `wr_data` until `wr_ready` is high. While the register is locked or recall is running, `wr_ready` stays low. The read side is a held level and needs no handshake.

## Verification
Several properties are checked on every cycle:
- the load strobe lasts one cycle and never comes back once `boot_done` has been seen;
- `boot_done` is sticky;
- a storage write only ever follows a stop;
- a locked register never changes;
- nothing is acknowledged or accepted during recall.

Other behaviour depends on concrete stimulus and only the bench scenarios can show it: which seed each recall code produces, the field decoding, staging until the stop, and lock persistence through a reset with the stored byte fed back.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int CFG_W  = 8;
  localparam int TYPE_W = 4;
  localparam logic [TYPE_W-1:0] CFG_SPACE_TYPE = 4'b1001;
  localparam logic [CFG_W-1:0]  CFG_BLANK      = 8'h56;
  localparam int LOCK_BIT = 0;
  localparam int HIZ_BIT  = 3;

  typedef enum logic [1:0] {
    RCL_ZERO = 2'b00,
    RCL_FULL = 2'b01,
    RCL_MID  = 2'b10,
    RCL_NV   = 2'b11
  } recall_e;

  typedef enum logic [1:0] {
    BS_CAPT = 2'd0,
    BS_LOAD = 2'd1,
    BS_RUN  = 2'd2
  } boot_e;
endpackage

// File: rtl/dcr_boot_seq.sv
module dcr_boot_seq
  import dcr_pkg::*;
#(
  parameter int NUM_DAC = 2,
  parameter int DAC_W   = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               recall_sel,
  input  logic [NUM_DAC*DAC_W-1:0] nv_dac,
  output logic                     capture,
  output logic                     boot_done,
  output logic [NUM_DAC-1:0]       dac_load,
  output logic [NUM_DAC*DAC_W-1:0] dac_value
);
  localparam logic [DAC_W-1:0] V_ZERO = '0;
  localparam logic [DAC_W-1:0] V_FULL = '1;
  localparam logic [DAC_W-1:0] V_MID  = DAC_W'(1) << (DAC_W - 1);

  boot_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BS_CAPT;
    else begin
      case (st_q)
        BS_CAPT: st_q <= BS_LOAD;
        BS_LOAD: st_q <= BS_RUN;
        default: st_q <= BS_RUN;
      endcase
    end
  end

  assign capture   = (st_q == BS_CAPT);
  assign boot_done = (st_q == BS_RUN);

  for (genvar k = 0; k < NUM_DAC; k++) begin : g_ch
    logic             ld_q;
    logic [DAC_W-1:0] val_q;
    logic [DAC_W-1:0] pick;

    always_comb begin
      case (recall_e'(recall_sel))
        RCL_ZERO: pick = V_ZERO;
        RCL_FULL: pick = V_FULL;
        RCL_MID:  pick = V_MID;
        default:  pick = nv_dac[k*DAC_W +: DAC_W];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ld_q  <= 1'b0;
        val_q <= '0;
      end else begin
        ld_q <= (st_q == BS_LOAD);
        if (st_q == BS_LOAD) val_q <= pick;
      end
    end

    assign dac_load[k]                 = ld_q;
    assign dac_value[k*DAC_W +: DAC_W] = val_q;
  end

  // R1
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_load != '0) |=> (dac_load == '0));
  // R1
  load_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && $past(boot_done)) |-> (dac_load == '0));
  // R1
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);
endmodule

// File: rtl/dcr_cfg_store.sv
module dcr_cfg_store
  import dcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              boot_done,
  input  logic [CFG_W-1:0]  nv_cfg_rd,
  input  logic [TYPE_W-1:0] bus_type,
  input  logic              wr_valid,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              bus_stop,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [CFG_W-1:0]  rd_data,
  output logic              cfg_addr_ack,
  output logic              dac_addr_ack,
  output logic              nv_cfg_wr_en,
  output logic [CFG_W-1:0]  nv_cfg_wr_data,
  output logic [CFG_W-1:0]  cfg_q
);
  logic [CFG_W-1:0] stage_q;
  logic             pend_q;
  logic             locked, open, accept, commit;

  assign locked = cfg_q[LOCK_BIT];
  assign open   = boot_done && !locked;
  assign accept = wr_valid && wr_ready;
  assign commit = bus_stop && pend_q;

  assign wr_ready     = open;
  assign rd_valid     = open;
  assign rd_data      = open ? cfg_q : '0;
  assign cfg_addr_ack = open && (bus_type == CFG_SPACE_TYPE);
  assign dac_addr_ack = boot_done && !cfg_addr_ack
                        && (bus_type == cfg_q[CFG_W-1 -: TYPE_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q          <= CFG_BLANK;
      stage_q        <= '0;
      pend_q         <= 1'b0;
      nv_cfg_wr_en   <= 1'b0;
      nv_cfg_wr_data <= '0;
    end else begin
      nv_cfg_wr_en <= commit;
      if (capture) cfg_q <= nv_cfg_rd;
      else if (commit) begin
        cfg_q          <= stage_q;
        nv_cfg_wr_data <= stage_q;
      end
      if (accept) begin
        stage_q <= wr_data;
        pend_q  <= 1'b1;
      end else if (bus_stop) pend_q <= 1'b0;
    end
  end

  // R8
  nvwr_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_cfg_wr_en |-> $past(bus_stop));
  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked) && !capture) |-> $stable(cfg_q));
  // R10
  no_ack_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> (!cfg_addr_ack && !dac_addr_ack && !wr_ready));
  // R9
  locked_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!wr_ready && !rd_valid && !cfg_addr_ack));
endmodule

// File: rtl/dac_cfg_recall.sv
module dac_cfg_recall
  import dcr_pkg::*;
#(
  parameter int NUM_DAC = 2,
  parameter int DAC_W   = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               nv_cfg_rd,
  input  logic [NUM_DAC*DAC_W-1:0] nv_dac_rd,
  output logic                     nv_cfg_wr_en,
  output logic [7:0]               nv_cfg_wr_data,
  input  logic [3:0]               bus_type,
  output logic                     cfg_addr_ack,
  output logic                     dac_addr_ack,
  input  logic                     wr_valid,
  input  logic [7:0]               wr_data,
  output logic                     wr_ready,
  input  logic                     bus_stop,
  output logic                     rd_valid,
  output logic [7:0]               rd_data,
  output logic [3:0]               dev_type,
  output logic                     pd_hiz,
  output logic                     boot_done,
  output logic [NUM_DAC-1:0]       dac_load,
  output logic [NUM_DAC*DAC_W-1:0] dac_value
);
  logic             capture;
  logic [CFG_W-1:0] cfg_q;

  dcr_cfg_store u_store (
    .clk            (clk),
    .rst_n          (rst_n),
    .capture        (capture),
    .boot_done      (boot_done),
    .nv_cfg_rd      (nv_cfg_rd),
    .bus_type       (bus_type),
    .wr_valid       (wr_valid),
    .wr_data        (wr_data),
    .bus_stop       (bus_stop),
    .wr_ready       (wr_ready),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .cfg_addr_ack   (cfg_addr_ack),
    .dac_addr_ack   (dac_addr_ack),
    .nv_cfg_wr_en   (nv_cfg_wr_en),
    .nv_cfg_wr_data (nv_cfg_wr_data),
    .cfg_q          (cfg_q)
  );

  dcr_boot_seq #(.NUM_DAC(NUM_DAC), .DAC_W(DAC_W)) u_boot (
    .clk        (clk),
    .rst_n      (rst_n),
    .recall_sel (cfg_q[2:1]),
    .nv_dac     (nv_dac_rd),
    .capture    (capture),
    .boot_done  (boot_done),
    .dac_load   (dac_load),
    .dac_value  (dac_value)
  );

  assign dev_type = cfg_q[CFG_W-1 -: TYPE_W];
  assign pd_hiz   = cfg_q[HIZ_BIT];
endmodule

// File: tb/dac_cfg_recall_bench.sv
module dac_cfg_recall_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  nv_mem = 8'h56;
  logic [19:0] nv_dac_rd = '0;
  logic        nv_cfg_wr_en;
  logic [7:0]  nv_cfg_wr_data;
  logic [3:0]  bus_type = 4'h0;
  logic        cfg_addr_ack, dac_addr_ack;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        wr_ready, bus_stop = 1'b0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [3:0]  dev_type;
  logic        pd_hiz, boot_done;
  logic [1:0]  dac_load;
  logic [19:0] dac_value;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  bit          ended = 1'b0;

  always #5 clk = ~clk;

  dac_cfg_recall u_dac_cfg_recall (
    .clk(clk), .rst_n(rst_n), .nv_cfg_rd(nv_mem), .nv_dac_rd(nv_dac_rd),
    .nv_cfg_wr_en(nv_cfg_wr_en), .nv_cfg_wr_data(nv_cfg_wr_data),
    .bus_type(bus_type), .cfg_addr_ack(cfg_addr_ack), .dac_addr_ack(dac_addr_ack),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .bus_stop(bus_stop), .rd_valid(rd_valid), .rd_data(rd_data),
    .dev_type(dev_type), .pd_hiz(pd_hiz), .boot_done(boot_done),
    .dac_load(dac_load), .dac_value(dac_value));

  // storage model
  always @(posedge clk) if (nv_cfg_wr_en) nv_mem <= nv_cfg_wr_data;

  // recall vectors: stored cfg, stored codes ch1:ch0, expected seeds ch1:ch0, type, hiz
  localparam int NV = 5;
  localparam logic [7:0]  V_CFG  [NV] = '{8'h50, 8'hA2, 8'h3C, 8'h56, 8'hFE};
  localparam logic [19:0] V_NVD  [NV] = '{{10'h2AA, 10'h123}, {10'h2AA, 10'h123},
                                          {10'h2AA, 10'h123}, {10'h2AA, 10'h123},
                                          {10'h3FE, 10'h001}};
  localparam logic [19:0] V_EXP  [NV] = '{{10'h000, 10'h000}, {10'h3FF, 10'h3FF},
                                          {10'h200, 10'h200}, {10'h2AA, 10'h123},
                                          {10'h3FE, 10'h001}};
  localparam logic [3:0]  V_TYPE [NV] = '{4'h5, 4'hA, 4'h3, 4'h5, 4'hF};
  localparam logic        V_HIZ  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reset, then stop at the cycle where the load pulse is visible
  task automatic boot();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 ack during reset", {30'd0, cfg_addr_ack, wr_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no load before pulse", {30'd0, dac_load}, 0);
    chk("R10 not done yet", {31'd0, boot_done}, 0);
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    wr_valid = 1'b1; wr_data = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic stop_pulse();
    bus_stop = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 5000) begin
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_run();
      end
    end
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      nv_mem = V_CFG[i]; nv_dac_rd = V_NVD[i];
      boot();
      chk("R1 load strobe", {30'd0, dac_load}, 2'b11);
      chk("R1 done with pulse", {31'd0, boot_done}, 1);
      chk("R2/R3/R4 seed values", {12'd0, dac_value}, {12'd0, V_EXP[i]});
      chk("R5 dev_type", {28'd0, dev_type}, {28'd0, V_TYPE[i]});
      chk("R7 pd_hiz", {31'd0, pd_hiz}, {31'd0, V_HIZ[i]});
      @(negedge clk);
      chk("R1 single-cycle strobe", {30'd0, dac_load}, 0);
      chk("R1 done sticky", {31'd0, boot_done}, 1);
    end

    // blank store, address decode
    nv_mem = 8'h56; nv_dac_rd = {10'h2AA, 10'h123};
    boot();
    @(negedge clk);
    bus_type = 4'b1001; #1;
    chk("R6 cfg ack", {30'd0, cfg_addr_ack, dac_addr_ack}, 2'b10);
    bus_type = 4'b0101; #1;
    chk("R5 dac ack", {30'd0, cfg_addr_ack, dac_addr_ack}, 2'b01);
    bus_type = 4'b0110; #1;
    chk("R5 R6 no ack other", {30'd0, cfg_addr_ack, dac_addr_ack}, 0);
    chk("R11 read blank", {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, 8'h56});

    // staged write
    put(8'h36);
    chk("R8 staged not applied", {24'd0, rd_data}, 8'h56);
    chk("R11 dev_type before stop", {28'd0, dev_type}, 4'h5);
    chk("R8 no nv write yet", {31'd0, nv_cfg_wr_en}, 0);
    bus_stop = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0;
    chk("R8 nv write pulse", {23'd0, nv_cfg_wr_en, nv_cfg_wr_data}, {23'd0, 1'b1, 8'h36});
    chk("R8 committed", {20'd0, rd_data, dev_type}, {20'd0, 8'h36, 4'h3});
    @(negedge clk);
    chk("R8 pulse ends", {31'd0, nv_cfg_wr_en}, 0);
    stop_pulse();
    chk("R8 empty stop no write", {31'd0, nv_cfg_wr_en}, 0);

    // lock
    put(8'h37);
    stop_pulse();
    chk("R9 lock committed to store", {23'd0, nv_cfg_wr_en, nv_cfg_wr_data}, {23'd0, 1'b1, 8'h37});
    bus_type = 4'b1001; #1;
    chk("R9 locked closed", {28'd0, wr_ready, rd_valid, cfg_addr_ack, 1'b0}, 0);
    chk("R9 locked read zero", {24'd0, rd_data}, 0);
    wr_valid = 1'b1; wr_data = 8'h50;
    @(negedge clk);
    wr_valid = 1'b0;
    stop_pulse();
    chk("R9 no commit when locked", {31'd0, nv_cfg_wr_en}, 0);
    chk("R9 type unchanged", {28'd0, dev_type}, 4'h3);

    // persistence over reset
    boot();
    chk("R9 stored lock kept", {24'd0, nv_mem}, 8'h37);
    chk("R4 recall after lock", {12'd0, dac_value}, {12'd0, 10'h2AA, 10'h123});
    bus_type = 4'b1001; #1;
    chk("R9 lock persists", {29'd0, cfg_addr_ack, wr_ready, rd_valid}, 0);
    bus_type = 4'b0011; #1;
    chk("R5 dac ack new type", {31'd0, dac_addr_ack}, 1);

    finish_run();
  end
endmodule